// File: doc/BRIEF.md
# Token-Passing Queue Lock

This block arbitrates one shared lock among a fixed set of requesters. Contending spinners never poll a common word. Instead, each requester that asks for the lock draws a sequence number from a central ticket counter in one atomic step. It then waits on a private slot flag indexed by that number. There is exactly one flag per requester, numbered 0 to NREQ-1. The slot index is the ticket modulo NREQ, and the counter wraps the same way.

The current owner gives the lock up by raising the flag of the slot that follows its own ticket. No read-modify-write of shared state is needed. The waiter holding that ticket sees its flag, takes ownership and clears the flag in the same step. Ownership therefore moves strictly first-come first-served by ticket. After reset, slot 0 is the one that is available.

Each requester drives a one-cycle acquire pulse and a one-cycle release pulse. It watches a registered grant output. A release pulse from a requester that does not own the lock changes nothing and raises a one-cycle error flag.

Top module: `qlock_unit`

## Requirements
- R1: After reset every grant output and the error flag are low, the ticket counter is 0 and only slot 0 is available, so the first requester to acquire is granted without any release.
- R2: An acquire pulse from an idle requester, sampled at clock edge k, takes the current ticket value; the counter advances by one, wrapping from NREQ-1 to 0.
- R3: When several idle requesters pulse acquire in the same cycle, tickets are handed out in ascending order of requester index (bit 0 first).
- R4: A waiting requester whose slot flag is set sees its grant output go high after the next clock edge; with a free lock, an acquire sampled at edge k gives grant high after edge k+1.
- R5: At most one grant output is high in any cycle.
- R6: A release pulse from the owner, sampled at edge k, drops its grant after edge k and sets the slot following its ticket; a requester waiting on that slot is granted after edge k+1.
- R7: Ownership passes in ticket order, independently of requester index.
- R8: Ticket NREQ-1 is followed by ticket 0, and the owner of ticket NREQ-1 hands the lock to slot 0.
- R9: A release pulse from a requester that is not the owner leaves the grants and the queue unchanged and sets the error flag high for exactly the cycle after the edge that sampled it.
- R10: An acquire pulse from a requester that is already waiting or owning is ignored and consumes no ticket.
- R11: A slot flag is cleared in the same step that grants it; at any time exactly one token exists, either as one set flag or as one owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | NREQ | Per-requester acquire pulse (bit i = requester i) |
| rel_i | input | NREQ | Per-requester release pulse |
| grant_o | output | NREQ | Per-requester ownership, registered |
| rel_err_o | output | 1 | One-cycle flag for a release from a non-owner |

## Verification
The assertions assume that requesters behave as queue clients. Each holds at most one ticket, so no more than NREQ tickets are ever outstanding. Under that assumption a set and a clear never land on the same slot, and the token count stays at one. The block enforces this itself by ignoring acquires from requesters that are not idle. The stimulus nevertheless keeps every requester to the acquire-wait-release cycle, apart from a deliberate repeated acquire and a stray release. Both of those are exactly the cases the block must absorb without changing its queue.

// File: rtl/qlock_pkg.sv
package qlock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } req_state_e;

    // successor of a ticket or slot index, wrapping at n-1
    function automatic int unsigned wrap_inc(int unsigned x, int unsigned n);
        return (x >= n - 1) ? 0 : x + 1;
    endfunction

endpackage

// File: rtl/qlock_ticket.sv
module qlock_ticket #(
    parameter int NREQ = 4,
    parameter int TW   = 2
) (
    input  logic [TW-1:0]            tail_i,
    input  logic [NREQ-1:0]          take_i,
    output logic [NREQ-1:0][TW-1:0]  tkt_o,
    output logic [TW-1:0]            tail_next_o
);
    import qlock_pkg::*;

    // Tickets are dealt out by ascending requester index.
    always_comb begin
        logic [TW-1:0] run;
        run = tail_i;
        for (int i = 0; i < NREQ; i++) begin
            tkt_o[i] = run;
            if (take_i[i]) begin
                run = TW'(wrap_inc(int'(run), NREQ));
            end
        end
        tail_next_o = run;
    end

endmodule

// File: rtl/qlock_slots.sv
module qlock_slots #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] set_i,
    input  logic [NREQ-1:0] clr_i,
    output logic [NREQ-1:0] flag_o
);
    logic [NREQ-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= NREQ'(1);
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    for (genvar j = 0; j < NREQ; j++) begin : g_chk
        // R11
        slot_set_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[j] |-> !flag_q[j]);
        // R11
        slot_clear_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[j] |=> !flag_q[j]);
    end

endmodule

// File: rtl/qlock_unit.sv
module qlock_unit #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] acq_i,
    input  logic [NREQ-1:0] rel_i,
    output logic [NREQ-1:0] grant_o,
    output logic            rel_err_o
);
    import qlock_pkg::*;

    localparam int TW = (NREQ > 1) ? $clog2(NREQ) : 1;

    typedef struct packed {
        req_state_e [NREQ-1:0]          st;
        logic       [NREQ-1:0][TW-1:0]  tkt;
        logic       [TW-1:0]            tail;
        logic                           err;
    } core_t;

    core_t r_d, r_q;

    logic [NREQ-1:0]         take;
    logic [NREQ-1:0][TW-1:0] tkt_new;
    logic [TW-1:0]           tail_new;
    logic [NREQ-1:0]         slot_set, slot_clr, slot_flag;
    logic [NREQ-1:0]         holding;

    qlock_ticket #(.NREQ(NREQ), .TW(TW)) ticket_i (
        .tail_i      (r_q.tail),
        .take_i      (take),
        .tkt_o       (tkt_new),
        .tail_next_o (tail_new)
    );

    qlock_slots #(.NREQ(NREQ)) slots_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (slot_set),
        .clr_i  (slot_clr),
        .flag_o (slot_flag)
    );

    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            take[i]    = acq_i[i] && (r_q.st[i] == ST_IDLE);
            holding[i] = (r_q.st[i] == ST_HOLD);
        end
    end

    always_comb begin
        r_d      = r_q;
        slot_set = '0;
        slot_clr = '0;
        r_d.tail = tail_new;
        r_d.err  = |(rel_i & ~holding);
        for (int i = 0; i < NREQ; i++) begin
            unique case (r_q.st[i])
                ST_IDLE: begin
                    if (take[i]) begin
                        r_d.st[i]  = ST_WAIT;
                        r_d.tkt[i] = tkt_new[i];
                    end
                end
                ST_WAIT: begin
                    if (slot_flag[r_q.tkt[i]]) begin
                        r_d.st[i]               = ST_HOLD;
                        slot_clr[r_q.tkt[i]]    = 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rel_i[i]) begin
                        r_d.st[i] = ST_IDLE;
                        slot_set[TW'(wrap_inc(int'(r_q.tkt[i]), NREQ))] = 1'b1;
                    end
                end
                default: r_d.st[i] = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= {NREQ{ST_IDLE}};
            r_q.tkt  <= '0;
            r_q.tail <= '0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign grant_o   = holding;
    assign rel_err_o = r_q.err;

    // R5
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R11
    one_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(slot_flag) + $countones(grant_o)) == 1);

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        // R6
        release_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_i[g] && grant_o[g]) |=> !grant_o[g]);
        // R9
        stray_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_i[g] && !grant_o[g]) |=> rel_err_o);
        // R9
        stray_keeps_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rel_i[g] && grant_o[g]) |=> grant_o[g]);
    end

endmodule

// File: tb/qlock_unit_tb_top.sv
module qlock_unit_tb_top;

    localparam int NREQ   = 4;
    localparam int NROWS  = 24;
    localparam int WD_CYC = 5000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] acq = '0;
    logic [NREQ-1:0] rel = '0;
    logic [NREQ-1:0] grant;
    logic            rel_err;

    int checks = 0;
    int fails  = 0;
    bit reported = 1'b0;

    always #5 clk = ~clk;

    qlock_unit #(.NREQ(NREQ)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acq_i     (acq),
        .rel_i     (rel),
        .grant_o   (grant),
        .rel_err_o (rel_err)
    );

    // row = {acquire, release, expected grant, expected error}
    localparam logic [12:0] VEC [NROWS] = '{
        {4'b0001, 4'b0000, 4'b0000, 1'b0}, // 0  r0 ticket 0
        {4'b0000, 4'b0000, 4'b0001, 1'b0}, // 1  r0 granted
        {4'b0110, 4'b0000, 4'b0001, 1'b0}, // 2  r1 t1, r2 t2
        {4'b0000, 4'b0001, 4'b0000, 1'b0}, // 3  r0 releases
        {4'b0000, 4'b0000, 4'b0010, 1'b0}, // 4  r1 granted
        {4'b1001, 4'b0000, 4'b0010, 1'b0}, // 5  r0 t3, r3 t0
        {4'b0000, 4'b0010, 4'b0000, 1'b0}, // 6  r1 releases
        {4'b0000, 4'b0000, 4'b0100, 1'b0}, // 7  r2 granted
        {4'b0000, 4'b1000, 4'b0100, 1'b1}, // 8  stray release r3
        {4'b0000, 4'b0100, 4'b0000, 1'b0}, // 9  r2 releases
        {4'b0000, 4'b0000, 4'b0001, 1'b0}, // 10 r0 (t3) granted
        {4'b0001, 4'b0000, 4'b0001, 1'b0}, // 11 owner re-acquire
        {4'b0000, 4'b0001, 4'b0000, 1'b0}, // 12 release t3 -> slot 0
        {4'b0000, 4'b0000, 4'b1000, 1'b0}, // 13 r3 (t0) granted
        {4'b0000, 4'b1000, 4'b0000, 1'b0}, // 14 r3 releases
        {4'b0010, 4'b0000, 4'b0000, 1'b0}, // 15 r1 t1
        {4'b0000, 4'b0000, 4'b0010, 1'b0}, // 16 r1 granted
        {4'b0000, 4'b0010, 4'b0000, 1'b0}, // 17 r1 releases
        {4'b0010, 4'b0000, 4'b0000, 1'b0}, // 18 r1 t2
        {4'b0010, 4'b0000, 4'b0010, 1'b0}, // 19 repeat acquire ignored
        {4'b0100, 4'b0000, 4'b0010, 1'b0}, // 20 r2 t3
        {4'b0000, 4'b0010, 4'b0000, 1'b0}, // 21 r1 releases
        {4'b0000, 4'b0000, 4'b0100, 1'b0}, // 22 r2 granted
        {4'b0000, 4'b0100, 4'b0000, 1'b0}  // 23 r2 releases
    };

    function automatic string row_tag(int r);
        case (r)
            0, 1:           return "R4";
            2, 5:           return "R3";
            3, 6, 9, 17:    return "R6";
            4, 7, 16, 22:   return "R7";
            8:              return "R9";
            10, 12, 13:     return "R8";
            11, 19, 20:     return "R10";
            default:        return "R2";
        endcase
    endfunction

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // reset, driven on the falling edge
        repeat (3) @(negedge clk);
        // R1: reset state
        check_val("R1 grant", 32'(grant), 32'h0);
        check_val("R1 err", 32'(rel_err), 32'h0);
        rst_n = 1'b1;

        for (int r = 0; r < NROWS; r++) begin
            acq = VEC[r][12:9];
            rel = VEC[r][8:5];
            @(negedge clk);
            check_val({row_tag(r), " grant"}, 32'(grant), 32'(VEC[r][4:1]));
            check_val({row_tag(r), " err"}, 32'(rel_err), 32'(VEC[r][0]));
            // R5
            check_val("R5 onehot", 32'($countones(grant) <= 1), 32'h1);
        end
        acq = '0;
        rel = '0;

        // R9: stray release while nobody owns: no grant appears, flag one cycle
        rel = 4'b0001;
        @(negedge clk);
        rel = '0;
        check_val("R9 err high", 32'(rel_err), 32'h1);
        check_val("R9 no grant", 32'(grant), 32'h0);
        @(negedge clk);
        check_val("R9 err one cycle", 32'(rel_err), 32'h0);

        // R1: reset mid-run returns token to slot 0 (counter at 0 after table)
        acq = 4'b1000;
        @(negedge clk);
        acq = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check_val("R1 grant after reset", 32'(grant), 32'h0);
        rst_n = 1'b1;
        acq = 4'b0100;
        @(negedge clk);
        acq = '0;
        check_val("R1 not yet", 32'(grant), 32'h0);
        @(negedge clk);
        check_val("R1 first owner", 32'(grant), 32'h4);

        // R2/R8: all four queue behind r2; tickets 1..3 then 0 wraps
        acq = 4'b1011;
        @(negedge clk);
        acq = '0;
        // order expected: r0 (t1), r1 (t2), r3 (t3)
        rel = 4'b0100;
        @(negedge clk);
        rel = '0;
        @(negedge clk);
        check_val("R2 next r0", 32'(grant), 32'h1);
        rel = 4'b0001;
        @(negedge clk);
        rel = '0;
        @(negedge clk);
        check_val("R7 next r1", 32'(grant), 32'h2);
        rel = 4'b0010;
        @(negedge clk);
        rel = '0;
        @(negedge clk);
        check_val("R8 next r3", 32'(grant), 32'h8);
        acq = 4'b0001; // gets ticket 0 after wrap
        @(negedge clk);
        acq = '0;
        rel = 4'b1000;
        @(negedge clk);
        rel = '0;
        check_val("R6 drop", 32'(grant), 32'h0);
        @(negedge clk);
        check_val("R8 wrapped r0", 32'(grant), 32'h1);

        finish_run();
    end

endmodule